// File: doc/BRIEF.md
# Two-Channel Image Bus DMA Master

This block is a bus-mastering DMA engine for an 8-bit data, 24-bit address image bus. It has two channels, each tied to one direction. Channel 0 writes bytes from the I/O side into image memory. Channel 1 reads bytes from image memory toward the I/O side.

Each channel is programmed with a start address and a byte count. A channel is armed while its count is non-zero. It is serviced when its active-low request input is low. For each byte the engine does the following, in order:

- requests the bus and waits for the grant;
- drives the address, the direction, an address-valid strobe and the channel's acknowledge;
- holds that access until the external end-of-access acknowledge arrives;
- releases the bus and flags the end of the cycle.

The bus is released after every single byte, so the other channel can be serviced between bytes. Status outputs mark the time a transfer is running, the end of each cycle, and the completion of a block.

Top module: `img_dma`

## Requirements
- R1: After reset, breq_no, aen_no, both dack_no bits and drun_no are high. dend_o, dcmp_o and rd_valid_o are low. ia_oe_o, id_oe_o and rw_oe_o are low.
- R2: A channel with a count of zero is never serviced. With dreq_ni low on such a channel, breq_no stays high.
- R3: An armed channel with dreq_ni low is seen in idle. breq_no goes low after one clock edge and stays low while bgnt_ni is high. During that wait aen_no stays high and all output enables stay low.
- R4: The first edge with bgnt_ni low starts the access. From the next cycle until iack_ni is sampled low, the following hold:
  - aen_no is low and ia_o equals the channel address;
  - rw_o is 0 (write) for channel 0 and 1 (read) for channel 1;
  - the serviced channel's dack_no bit is low;
  - ia_oe_o and rw_oe_o are high.

  Every output enable is low whenever bgnt_ni is high.
- R5: The edge that samples iack_ni low during an access ends that access. In the following cycle:
  - dend_o is high for exactly one cycle;
  - breq_no, aen_no and dack_no are high;
  - all output enables are low.
- R6: Each completed byte increments the channel address by one, wrapping modulo 2^24, and decrements its count. dcmp_o is high together with dend_o on the byte that takes the count to zero, and only on that byte.
- R7: When both channels are pending and neither has been served since reset, channel 0 goes first. After a byte on one channel, a pending request on the other channel is serviced next.
- R8: During a channel 0 access, id_oe_o is high and id_o equals wr_byte_i. During a channel 1 access, id_oe_o is low. The id_i value sampled with iack_ni appears on rd_byte_o, with rd_valid_o high, in the dend_o cycle.
- R9: drun_no is low from the cycle breq_no goes low through the dend_o cycle. It is high in idle.
- R10: A configuration write to the channel being serviced is ignored. Writes to that channel take effect only in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 1 | Channel selected by the write |
| cfg_cnt_i | input | 1 | 1: write the byte count, 0: write the start address |
| cfg_data_i | input | 24 | Configuration value |
| dreq_ni | input | 2 | Active-low per-channel requests (bit 0 writes memory, bit 1 reads memory) |
| dack_no | output | 2 | Active-low per-channel acknowledges |
| breq_no | output | 1 | Active-low bus request |
| bgnt_ni | input | 1 | Active-low bus grant |
| aen_no | output | 1 | Active-low address valid |
| ia_o | output | 24 | Image address |
| ia_oe_o | output | 1 | Address output enable |
| rw_o | output | 1 | Direction, 1 read memory / 0 write memory |
| rw_oe_o | output | 1 | Direction output enable |
| id_o | output | 8 | Image data driven on writes |
| id_oe_o | output | 1 | Data output enable |
| id_i | input | 8 | Image data sampled on reads |
| iack_ni | input | 1 | Active-low end-of-access acknowledge |
| wr_byte_i | input | 8 | Byte to write for channel 0 |
| rd_byte_o | output | 8 | Byte read by channel 1 |
| rd_valid_o | output | 1 | rd_byte_o valid |
| drun_no | output | 1 | Active-low transfer-running status |
| dend_o | output | 1 | End-of-cycle pulse |
| dcmp_o | output | 1 | Block-complete pulse |

## Verification
End of cycle and block completion can fall in the same cycle. Each short block is swept at its last byte, and dcmp_o is judged high with dend_o only on the byte that empties the count. Arbitration and completion can also meet. Both requests are held low while channel 0 finishes its block, and the bench judges that channel 1 is served next and that the emptied channel 0 is not served again.

// File: rtl/img_dma_pkg.sv
package img_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_ACC, ST_FIN} dma_state_e;
  localparam int unsigned NCH = 2;
endpackage

// File: rtl/img_dma_chan.sv
module img_dma_chan #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              is_cnt_i,
  input  logic [ADDR_W-1:0] data_i,
  input  logic              lock_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              zero_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + 1'b1;
      cnt_q  <= cnt_q - 1'b1;
    end else if (we_i && !lock_i) begin
      if (is_cnt_i) cnt_q  <= CNT_W'(data_i);
      else          addr_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign zero_o = (cnt_q == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !zero_o); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_i && !step_i) |=> (addr_q == $past(addr_q))); // R10
endmodule

// File: rtl/img_dma_arb.sv
module img_dma_arb (
  input  logic [1:0] pend_i,
  input  logic       last_i,
  output logic       any_o,
  output logic       pick_o
);
  always_comb begin
    any_o = |pend_i;
    if (&pend_i) pick_o = ~last_i;
    else         pick_o = pend_i[1];
  end
endmodule

// File: rtl/img_dma_seq.sv
module img_dma_seq
  import img_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              any_i,
  input  logic              pick_i,
  input  logic              sel_zero_i,
  input  logic              bgnt_ni,
  input  logic              iack_ni,
  input  logic [DATA_W-1:0] id_i,
  output logic              busy_o,
  output logic              sel_o,
  output logic              last_o,
  output logic              step_o,
  output logic              acc_o,
  output logic              breq_no,
  output logic              aen_no,
  output logic [1:0]        dack_no,
  output logic              drun_no,
  output logic              dend_o,
  output logic              dcmp_o,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              rd_valid_o
);
  dma_state_e        st_q, st_d;
  logic              sel_q, last_q;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (any_i)    st_d = ST_REQ;
      ST_REQ:  if (!bgnt_ni) st_d = ST_ACC;
      ST_ACC:  if (!iack_ni) st_d = ST_FIN;
      ST_FIN:                st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      last_q <= 1'b1;
      rd_q   <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && any_i) sel_q <= pick_i;
      if (st_q == ST_FIN) last_q <= sel_q;
      if (st_q == ST_ACC && !iack_ni && sel_q) rd_q <= id_i;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign sel_o      = sel_q;
  assign last_o     = last_q;
  assign step_o     = (st_q == ST_ACC) && !iack_ni;
  assign acc_o      = (st_q == ST_ACC) && !bgnt_ni;
  assign breq_no    = !(st_q == ST_REQ || st_q == ST_ACC);
  assign aen_no     = !acc_o;
  assign dack_no[0] = !(acc_o && !sel_q);
  assign dack_no[1] = !(acc_o && sel_q);
  assign drun_no    = !busy_o;
  assign dend_o     = (st_q == ST_FIN);
  assign dcmp_o     = dend_o && sel_zero_i;
  assign rd_byte_o  = rd_q;
  assign rd_valid_o = dend_o && sel_q;

  AST_AEN_UNDER_BREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aen_no |-> !breq_no); // R4
  AST_DACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~dack_no)); // R4
  AST_GNT_BEFORE_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(aen_no) |-> $past(!bgnt_ni)); // R3
  AST_DEND_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dend_o |=> !dend_o); // R5
  AST_DCMP_IN_DEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dcmp_o |-> dend_o); // R6
  AST_RUN_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !breq_no |-> !drun_no); // R9
endmodule

// File: rtl/img_dma.sv
module img_dma
  import img_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_ch_i,
  input  logic              cfg_cnt_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic [1:0]        dreq_ni,
  output logic [1:0]        dack_no,
  output logic              breq_no,
  input  logic              bgnt_ni,
  output logic              aen_no,
  output logic [ADDR_W-1:0] ia_o,
  output logic              ia_oe_o,
  output logic              rw_o,
  output logic              rw_oe_o,
  output logic [DATA_W-1:0] id_o,
  output logic              id_oe_o,
  input  logic [DATA_W-1:0] id_i,
  input  logic              iack_ni,
  input  logic [DATA_W-1:0] wr_byte_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              rd_valid_o,
  output logic              drun_no,
  output logic              dend_o,
  output logic              dcmp_o
);
  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [NCH-1:0]    ch_zero;
  logic [NCH-1:0]    pend;
  logic              busy, sel, last, step, acc, any, pick;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    img_dma_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (cfg_we_i && (cfg_ch_i == c[0])),
      .is_cnt_i (cfg_cnt_i),
      .data_i   (cfg_data_i),
      .lock_i   (busy && (sel == c[0])),
      .step_i   (step && (sel == c[0])),
      .addr_o   (ch_addr[c]),
      .zero_o   (ch_zero[c])
    );
    assign pend[c] = !ch_zero[c] && !dreq_ni[c];
  end

  img_dma_arb u_arb (
    .pend_i (pend),
    .last_i (last),
    .any_o  (any),
    .pick_o (pick)
  );

  img_dma_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any),
    .pick_i     (pick),
    .sel_zero_i (ch_zero[sel]),
    .bgnt_ni    (bgnt_ni),
    .iack_ni    (iack_ni),
    .id_i       (id_i),
    .busy_o     (busy),
    .sel_o      (sel),
    .last_o     (last),
    .step_o     (step),
    .acc_o      (acc),
    .breq_no    (breq_no),
    .aen_no     (aen_no),
    .dack_no    (dack_no),
    .drun_no    (drun_no),
    .dend_o     (dend_o),
    .dcmp_o     (dcmp_o),
    .rd_byte_o  (rd_byte_o),
    .rd_valid_o (rd_valid_o)
  );

  assign ia_o    = ch_addr[sel];
  assign ia_oe_o = acc;
  assign rw_o    = sel;
  assign rw_oe_o = acc;
  assign id_o    = wr_byte_i;
  assign id_oe_o = acc && !sel;

  AST_OE_NEEDS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ia_oe_o || id_oe_o || rw_oe_o) |-> !bgnt_ni); // R4
  AST_DACK_MATCH_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_no[1] |-> rw_o); // R4
endmodule

// File: tb/img_dma_bench.sv
module img_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_ch = 1'b0, cfg_cnt = 1'b0;
  logic [23:0] cfg_data = '0;
  logic [1:0]  dreq_n = 2'b11;
  logic [1:0]  dack_n;
  logic        breq_n, bgnt_n = 1'b1, aen_n;
  logic [23:0] ia;
  logic        ia_oe, rw, rw_oe, id_oe, iack_n = 1'b1;
  logic [7:0]  id_out, id_in = '0, wr_byte = '0, rd_byte;
  logic        rd_valid, drun_n, dend, dcmp;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  img_dma u_img_dma (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_cnt_i(cfg_cnt), .cfg_data_i(cfg_data), .dreq_ni(dreq_n),
    .dack_no(dack_n), .breq_no(breq_n), .bgnt_ni(bgnt_n), .aen_no(aen_n),
    .ia_o(ia), .ia_oe_o(ia_oe), .rw_o(rw), .rw_oe_o(rw_oe), .id_o(id_out),
    .id_oe_o(id_oe), .id_i(id_in), .iack_ni(iack_n), .wr_byte_i(wr_byte),
    .rd_byte_o(rd_byte), .rd_valid_o(rd_valid), .drun_no(drun_n),
    .dend_o(dend), .dcmp_o(dcmp)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic ch, input logic is_cnt, input logic [23:0] v);
    cfg_we = 1'b1; cfg_ch = ch; cfg_cnt = is_cnt; cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Starts at a negedge in idle with the channel pending; ends at a negedge back in idle.
  task automatic xfer(input logic ch, input logic [23:0] ea, input logic ecmp,
                      input int gd, input int ad, input logic poke, input logic [7:0] b);
    @(negedge clk);
    chk(!breq_n && aen_n && !drun_n, "R3 breq", {breq_n, aen_n, drun_n}, 3'b010);
    chk(!ia_oe && !id_oe && !rw_oe, "R3 oe off", {ia_oe, id_oe, rw_oe}, 0);
    for (int i = 0; i < gd; i++) begin
      if (poke && i == 0) begin
        cfg_wr(ch, 1'b0, 24'hABCDEF);
      end else begin
        @(negedge clk);
      end
      chk(!breq_n && aen_n && !ia_oe, "R3 wait", {breq_n, aen_n, ia_oe}, 3'b010);
    end
    bgnt_n = 1'b0;
    wr_byte = b;
    @(negedge clk);
    for (int i = 0; i <= ad; i++) begin
      chk(!aen_n && ia == ea, "R4 addr", ia, ea);
      chk(poke ? ia == ea : 1'b1, "R10 locked write", ia, ea);
      chk(rw == ch && ia_oe && rw_oe, "R4 rw", {rw, ia_oe, rw_oe}, {ch, 2'b11});
      chk(dack_n == (ch ? 2'b01 : 2'b10), "R4 dack", dack_n, ch ? 2'b01 : 2'b10);
      chk(id_oe == !ch && (ch || id_out == b), "R8 wdata", {id_oe, id_out}, {!ch, b});
      chk(!drun_n, "R9 run", drun_n, 0);
      if (i == ad) begin
        iack_n = 1'b0;
        id_in = b;
      end
      @(negedge clk);
    end
    iack_n = 1'b1;
    bgnt_n = 1'b1;
    chk(dend && dcmp == ecmp, "R6 dend/dcmp", {dend, dcmp}, {1'b1, ecmp});
    chk(breq_n && aen_n && dack_n == 2'b11 && !ia_oe && !id_oe, "R5 release",
        {breq_n, aen_n, dack_n, ia_oe, id_oe}, 6'b111100);
    chk(!drun_n, "R9 run in dend", drun_n, 0);
    chk(rd_valid == ch && (!ch || rd_byte == b), "R8 rdata", {rd_valid, rd_byte}, {ch, b});
    @(negedge clk);
    chk(!dend && breq_n && drun_n, "R5 pulse end", {dend, breq_n, drun_n}, 3'b011);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog act=1 exp=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    join_none

    @(negedge clk);
    chk(breq_n && aen_n && dack_n == 2'b11 && drun_n, "R1 strobes", {breq_n, aen_n, dack_n, drun_n}, 5'h1f);
    chk(!dend && !dcmp && !rd_valid && !ia_oe && !id_oe && !rw_oe, "R1 outputs",
        {dend, dcmp, rd_valid, ia_oe, id_oe, rw_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: request with zero count is ignored
    dreq_n = 2'b00;
    repeat (4) begin
      @(negedge clk);
      chk(breq_n && drun_n, "R2 unarmed", {breq_n, drun_n}, 2'b11);
    end
    dreq_n = 2'b11;

    // Sweep: both channels, counts 1..3, varying delays, an address wrap
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 1; n <= 3; n++) begin
        logic [23:0] base;
        base = (n == 2) ? 24'hFFFFFF : 24'h000100 * (ch + 1) + 24'(n * 16);
        cfg_wr(ch[0], 1'b0, base);
        cfg_wr(ch[0], 1'b1, 24'(n));
        dreq_n[ch] = 1'b0;
        for (int k = 0; k < n; k++) begin
          xfer(ch[0], base + 24'(k), k == n - 1, (k + ch) % 3, (k + n) % 3,
               1'b0, 8'(8'h30 + ch * 8 + n * 3 + k));
        end
        repeat (3) begin
          @(negedge clk);
          chk(breq_n, "R2 done channel idle", breq_n, 1);
        end
        dreq_n[ch] = 1'b1;
      end
    end

    // R10: write to active channel ignored, applies next byte check
    cfg_wr(1'b0, 1'b0, 24'h000500);
    cfg_wr(1'b0, 1'b1, 24'd2);
    dreq_n = 2'b10;
    xfer(1'b0, 24'h000500, 1'b0, 2, 0, 1'b1, 8'h5A);
    xfer(1'b0, 24'h000501, 1'b1, 0, 1, 1'b0, 8'h5B);
    dreq_n = 2'b11;

    // R7: simultaneous requests, alternation, channel 0 empties first
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cfg_wr(1'b0, 1'b0, 24'h001000);
    cfg_wr(1'b0, 1'b1, 24'd2);
    cfg_wr(1'b1, 1'b0, 24'h002000);
    cfg_wr(1'b1, 1'b1, 24'd3);
    dreq_n = 2'b00;
    xfer(1'b0, 24'h001000, 1'b0, 0, 0, 1'b0, 8'h11); // R7 ch0 first
    xfer(1'b1, 24'h002000, 1'b0, 1, 0, 1'b0, 8'h22); // R7 alternate
    xfer(1'b0, 24'h001001, 1'b1, 0, 2, 1'b0, 8'h33);
    xfer(1'b1, 24'h002001, 1'b0, 0, 0, 1'b0, 8'h44); // R7 after ch0 empties
    xfer(1'b1, 24'h002002, 1'b1, 2, 1, 1'b0, 8'h55);
    @(negedge clk);
    chk(breq_n, "R2 both empty", breq_n, 1);
    dreq_n = 2'b11;

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule